// File: doc/BRIEF.md
# Receive Data-Ready Strobe Generator

This block drives the active-low data-ready strobe of a serial receiver. It runs on the bit-rate clock. Once per byte it receives a one-cycle character strobe, together with a flag that says whether the decoded character is the K28.5 comma. It then decides whether that character should be announced to downstream logic. When an announcement is due, it draws a low pulse that covers the first 60% of a byte period (6 of 10 bit clocks), followed by a high phase for the remaining 40%.

In encoded mode every character is announced, with one exception: a run of K28.5 idle characters announces only its last comma. A lone K28.5 is announced as well. To know whether a comma is the last of its run, the block keeps each character in a one-character lookahead stage. The pulse for a character is therefore issued when the following character arrives. In unencoded mode only K28.5 characters are announced. While the framer reports that it is searching for byte alignment, the strobe is held high and any pulse in progress is cut short.

Top module: `rdy_strobe_gen`

## Requirements
- R1: While rst_ni is low the strobe is high and the lookahead stage is empty, so the first character accepted after reset produces no pulse.
- R2: In encoded mode (mode_enc_i = 1), a held non-comma character produces a pulse when the next character is accepted.
- R3: In encoded mode, a held K28.5 (is_comma_i = 1 when it was accepted) produces no pulse when the next accepted character is also K28.5.
- R4: In encoded mode, a held K28.5 produces a pulse when the next accepted character is not K28.5; this covers both a lone comma and the last comma of a run.
- R5: In unencoded mode (mode_enc_i = 0), a held character produces a pulse only if it is K28.5.
- R6: A pulse drives strobe_o low on the clock edge that accepts the next character and keeps it low for LOW_BITS (6) bit clocks. The strobe is then high for the rest of the BYTE_BITS (10) clock byte period.
- R7: While frm_search_i is high, strobe_o is high from the next clock edge on, and any pulse in progress is cancelled. Characters accepted during that time still load the lookahead stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_vld_i | input | 1 | One-cycle strobe marking a new decoded character |
| is_comma_i | input | 1 | The character accepted with char_vld_i is K28.5 |
| mode_enc_i | input | 1 | 1 = encoded mode, 0 = unencoded mode |
| frm_search_i | input | 1 | Framer is searching; forces the strobe high |
| strobe_o | output | 1 | Active-low data-ready strobe |

## Verification
Some properties are checked on every cycle: the low phase never exceeds LOW_BITS cycles, the strobe falls only on a character acceptance, the framer override forces the strobe high, and the first character after reset stays silent. The cases of the lookahead decision are also checked each cycle (comma followed by comma, comma followed by data, data in either mode), each against a comma history that the checker tracks from the ports. The full pulse shape is shown only by the bench's per-byte sample masks: exactly six low samples starting at the accepting edge, then a high tail. The same masks show the mid-pulse abort and the clearing of the lookahead stage on a reset in mid-stream.

// File: rtl/rdy_strobe_pkg.sv
package rdy_strobe_pkg;
  localparam int unsigned BYTE_BITS_DEF = 10;
  localparam int unsigned LOW_BITS_DEF  = 6;

  typedef struct packed {
    logic valid;
    logic comma;
  } char_slot_t;
endpackage

// File: rtl/rdy_lookahead.sv
module rdy_lookahead
  import rdy_strobe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       char_vld_i,
  input  logic       is_comma_i,
  output char_slot_t held_o
);
  char_slot_t slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
    end else if (char_vld_i) begin
      slot_q.valid <= 1'b1;
      slot_q.comma <= is_comma_i;
    end
  end

  assign held_o = slot_q;
endmodule

// File: rtl/rdy_decide.sv
module rdy_decide
  import rdy_strobe_pkg::*;
(
  input  logic       char_vld_i,
  input  logic       is_comma_i,
  input  logic       mode_enc_i,
  input  logic       frm_search_i,
  input  char_slot_t held_i,
  output logic       fire_o
);
  logic announce;

  always_comb begin
    if (mode_enc_i) begin
      // suppress a comma only if the next one is a comma too
      announce = !(held_i.comma && is_comma_i);
    end else begin
      announce = held_i.comma;
    end
    fire_o = char_vld_i && held_i.valid && !frm_search_i && announce;
  end
endmodule

// File: rtl/rdy_shaper.sv
module rdy_shaper #(
  parameter int unsigned BYTE_BITS = 10,
  parameter int unsigned LOW_BITS  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic strobe_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] LOW_PH  = CNT_W'(LOW_BITS);

  logic             run_q, run_d;
  logic [CNT_W-1:0] ph_q, ph_d;
  logic             strb_q, strb_d;

  always_comb begin
    run_d = run_q;
    ph_d  = ph_q;
    if (run_q) begin
      if (ph_q == LAST_PH) run_d = 1'b0;
      else                 ph_d  = ph_q + 1'b1;
    end
    if (start_i) begin
      run_d = 1'b1;
      ph_d  = '0;
    end
    if (abort_i) run_d = 1'b0;
    strb_d = !(run_d && (ph_d < LOW_PH));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ph_q   <= '0;
      strb_q <= 1'b1;
    end else begin
      run_q  <= run_d;
      ph_q   <= ph_d;
      strb_q <= strb_d;
    end
  end

  assign strobe_o = strb_q;
endmodule

// File: rtl/rdy_strobe_gen.sv
module rdy_strobe_gen
  import rdy_strobe_pkg::*;
#(
  parameter int unsigned BYTE_BITS = BYTE_BITS_DEF,
  parameter int unsigned LOW_BITS  = LOW_BITS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic char_vld_i,
  input  logic is_comma_i,
  input  logic mode_enc_i,
  input  logic frm_search_i,
  output logic strobe_o
);
  char_slot_t held;
  logic       fire;

  rdy_lookahead i_look (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .char_vld_i (char_vld_i),
    .is_comma_i (is_comma_i),
    .held_o     (held)
  );

  rdy_decide i_dec (
    .char_vld_i   (char_vld_i),
    .is_comma_i   (is_comma_i),
    .mode_enc_i   (mode_enc_i),
    .frm_search_i (frm_search_i),
    .held_i       (held),
    .fire_o       (fire)
  );

  rdy_shaper #(
    .BYTE_BITS (BYTE_BITS),
    .LOW_BITS  (LOW_BITS)
  ) i_shp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (fire),
    .abort_i  (frm_search_i),
    .strobe_o (strobe_o)
  );
endmodule

// File: rtl/rdy_strobe_gen_chk.sv
module rdy_strobe_gen_chk #(
  parameter int unsigned BYTE_BITS = 10,
  parameter int unsigned LOW_BITS  = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic char_vld_i,
  input logic is_comma_i,
  input logic mode_enc_i,
  input logic frm_search_i,
  input logic strobe_o
);
  localparam int unsigned LW = $clog2(BYTE_BITS + 2);

  logic          have_q, last_comma_q, up_q;
  logic [LW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q       <= 1'b0;
      last_comma_q <= 1'b0;
      up_q         <= 1'b0;
      low_cnt_q    <= '0;
    end else begin
      up_q <= 1'b1;
      if (char_vld_i) begin
        have_q       <= 1'b1;
        last_comma_q <= is_comma_i;
      end
      if (strobe_o) low_cnt_q <= '0;
      else if (low_cnt_q != LW'(BYTE_BITS + 1)) low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  // R6: low phase never longer than LOW_BITS
  a_r6_low_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt_q <= LW'(LOW_BITS));

  // R6: strobe only falls on a character acceptance
  a_r6_fall_on_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_q && $fell(strobe_o) |-> $past(char_vld_i));

  a_r7_search_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_search_i |=> strobe_o);

  a_r1_first_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_vld_i && !have_q |=> strobe_o);

  a_r3_run_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_vld_i && strobe_o && mode_enc_i && have_q && last_comma_q && is_comma_i
    |=> strobe_o);

  a_r4_last_comma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_vld_i && !frm_search_i && mode_enc_i && have_q && last_comma_q && !is_comma_i
    |=> !strobe_o);

  a_r2_data_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_vld_i && !frm_search_i && mode_enc_i && have_q && !last_comma_q
    |=> !strobe_o);

  a_r5_unenc_data_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_vld_i && strobe_o && !mode_enc_i && have_q && !last_comma_q
    |=> strobe_o);
endmodule

bind rdy_strobe_gen rdy_strobe_gen_chk #(
  .BYTE_BITS (BYTE_BITS),
  .LOW_BITS  (LOW_BITS)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .char_vld_i   (char_vld_i),
  .is_comma_i   (is_comma_i),
  .mode_enc_i   (mode_enc_i),
  .frm_search_i (frm_search_i),
  .strobe_o     (strobe_o)
);

// File: tb/test_rdy_strobe_gen.sv
module test_rdy_strobe_gen;
  localparam int unsigned BYTE_BITS = 10;
  localparam int unsigned LOW_BITS  = 6;
  localparam int unsigned NVEC      = 20;
  // {mode_enc, frm_search, is_comma}
  localparam logic [2:0] VEC [NVEC] = '{
    3'b100, 3'b100, 3'b101, 3'b100, 3'b101, 3'b101, 3'b101, 3'b100,
    3'b111, 3'b100, 3'b100, 3'b001, 3'b000, 3'b001, 3'b001, 3'b000,
    3'b000, 3'b001, 3'b100, 3'b100
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic char_vld = 1'b0, is_comma = 1'b0, mode_enc = 1'b1, frm_search = 1'b0;
  logic strobe;
  int checks = 0, fails = 0;
  logic prev_vld = 1'b0, prev_comma = 1'b0;

  always #5 clk = ~clk;

  rdy_strobe_gen #(.BYTE_BITS(BYTE_BITS), .LOW_BITS(LOW_BITS)) i_rdy_strobe_gen (
    .clk_i(clk), .rst_ni(rst_ni), .char_vld_i(char_vld), .is_comma_i(is_comma),
    .mode_enc_i(mode_enc), .frm_search_i(frm_search), .strobe_o(strobe)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // send one character, sample BYTE_BITS cycles, return low mask (1 = low)
  task automatic send(input logic enc, input logic busy, input logic cm, output logic [9:0] m);
    mode_enc = enc; frm_search = busy; is_comma = cm; char_vld = 1'b1;
    m = '0;
    for (int i = 0; i < BYTE_BITS; i++) begin
      @(negedge clk);
      if (i == 0) char_vld = 1'b0;
      m[i] = !strobe;
    end
  endtask

  localparam logic [9:0] PULSE = 10'b0000111111;

  initial begin
    logic [9:0] m, exp;
    string req;
    repeat (3) @(negedge clk);
    check("R1 reset strobe high", {9'b0, strobe}, 10'd1);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][2], VEC[v][1], VEC[v][0], m);
      if (!prev_vld) req = "R1 first char silent";
      else if (VEC[v][1]) req = "R7 search override";
      else if (!VEC[v][2]) req = "R5 unencoded";
      else if (prev_comma && VEC[v][0]) req = "R3 comma run suppressed";
      else if (prev_comma) req = "R4 last comma pulses";
      else req = "R2 data pulse R6 shape";
      exp = (prev_vld && !VEC[v][1] &&
             (VEC[v][2] ? !(prev_comma && VEC[v][0]) : prev_comma)) ? PULSE : '0;
      check(req, m, exp);
      prev_vld = 1'b1; prev_comma = VEC[v][0];
    end

    // R7: abort mid-pulse (held char is data)
    mode_enc = 1'b1; is_comma = 1'b0; char_vld = 1'b1;
    @(negedge clk); char_vld = 1'b0;
    check("R6 pulse starts", {9'b0, strobe}, 10'd0);
    @(negedge clk);
    frm_search = 1'b1;
    @(negedge clk);
    check("R7 abort mid-pulse", {9'b0, strobe}, 10'd1);
    frm_search = 1'b0;
    repeat (8) @(negedge clk);
    check("R7 stays high after abort", {9'b0, strobe}, 10'd1);

    // R1: reset mid-pulse clears stage
    char_vld = 1'b1; is_comma = 1'b0;
    @(negedge clk); char_vld = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset high", {9'b0, strobe}, 10'd1);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    send(1'b1, 1'b0, 1'b0, m);
    check("R1 first after reset silent", m, '0);
    send(1'b1, 1'b0, 1'b0, m);
    check("R2 second after reset pulses", m, PULSE);
    send(1'b0, 1'b0, 1'b1, m);
    check("R5 unencoded data held silent", m, '0);
    send(1'b0, 1'b0, 1'b0, m);
    check("R5 unencoded comma held pulses", m, PULSE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule